// File: doc/BRIEF.md
# LFPS U2 Exit Qualifier

This block filters the low-frequency periodic signalling (LFPS) detect flag from the PHY while the link sits in the U2 low-power state. It reports a genuine exit request with a single-cycle pulse and drops shorter bursts as glitches. A mode input selects one of two dwell times. The short dwell is 248 ns. The long dwell is 8 us. The long dwell lets the link stay in U2 when a partner emits stray LFPS while it probes for receiver termination.

The detect flag comes from an analog detector, so it passes through a synchronizer before the dwell counter sees it. The counter only accumulates while the link state machine reports U2. Any gap in the signal clears the count, and so does leaving U2. The mode input is captured when a burst begins and held until that burst ends. Dwell times are turned into clock cycles from the clock-period parameter, rounding up. The block has no host/device role input, so it behaves the same in either role.

Top module: `u2_exit_qual`

## Requirements
- R1: During and after reset, with no stimulus, `u2_exit_o` is low and no count is held.
- R2: With `long_filt_i` low, LFPS held for SHORT_CYC = ceil(248 ns / period) sampled cycles gives a pulse. With the defaults (5000 ps period, 2 sync stages) that is 50 cycles, and the pulse is visible in the cycle after the 52nd rising edge that follows the input rising.
- R3: With `long_filt_i` high, LFPS held for LONG_CYC = ceil(8000 ns / period) sampled cycles gives a pulse. With the defaults that is 1600 cycles, and the pulse follows the 1602nd edge.
- R4: A burst one cycle shorter than the active threshold gives no pulse. A drop of the synchronized input, even for one cycle, clears the count, so two sub-threshold pieces never add up.
- R5: While `in_u2_i` is low, no count builds up and no pulse appears. A one-cycle drop of `in_u2_i` restarts counting from zero. When `in_u2_i` rises while LFPS is already present, the pulse follows the THR-th edge after the rise.
- R6: Each burst gives at most one pulse, however long it lasts. LFPS must drop, for one sampled cycle or more, before another pulse can occur.
- R7: `long_filt_i` is sampled on the first cycle of a burst. Changing it later in the same burst does not change when, or whether, the pulse appears.
- R8: `u2_exit_o` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock, period CLK_PERIOD_PS |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lfps_det_i | input | 1 | LFPS detected flag from the PHY, asynchronous |
| in_u2_i | input | 1 | Link is in U2 (from the link state machine, same clock) |
| long_filt_i | input | 1 | 0: 248 ns dwell, 1: 8 us dwell |
| u2_exit_o | output | 1 | One-cycle valid U2 exit pulse |

## Verification
Two functions can land in the same cycle: the dwell count reaching its threshold, and the burst ending. The burst can end either because LFPS drops or because the link leaves U2.

The bench provokes this by ending bursts exactly at the threshold and one cycle short of it. It judges the result on whether a pulse exists and on the exact cycle it appears. It also raises and drops `in_u2_i` in the middle of a burst and checks that the pulse moves to the cycle the restart predicts.

Mode flips a few cycles after burst start are checked the same way. The flipped value must not affect the pulse timing in either direction.

// File: rtl/u2x_pkg.sv
`timescale 1ns/1ps
package u2x_pkg;

  typedef enum logic {
    FILT_SHORT = 1'b0,
    FILT_LONG  = 1'b1
  } filt_mode_e;

  // Duration in ns to clock cycles, rounded up.
  function automatic int unsigned cycles_for(input int unsigned dur_ns,
                                             input int unsigned period_ps);
    return (dur_ns * 1000 + period_ps - 1) / period_ps;
  endfunction

endpackage

// File: rtl/u2x_sync.sv
`timescale 1ns/1ps
module u2x_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  if (STAGES == 0) begin : g_bypass
    assign q_o = d_i;
  end else begin : g_chain
    logic [STAGES-1:0] ff_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q <= '0;
      else begin
        ff_q[0] <= d_i;
        for (int i = 1; i < STAGES; i++) ff_q[i] <= ff_q[i-1];
      end
    end
    assign q_o = ff_q[STAGES-1];
  end

endmodule

// File: rtl/u2x_burst_track.sv
`timescale 1ns/1ps
module u2x_burst_track
  import u2x_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lfps_s_i,
  input  logic       in_u2_i,
  input  filt_mode_e mode_i,
  output logic       active_o,
  output filt_mode_e mode_o
);

  logic       run_q;
  logic       start;
  filt_mode_e mode_q;

  assign active_o = lfps_s_i & in_u2_i;
  assign start    = active_o & ~run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      mode_q <= FILT_SHORT;
    end else begin
      run_q <= active_o;
      if (start) mode_q <= mode_i;
    end
  end

  // Settled mode used during a running burst; the first cycle is below any threshold.
  assign mode_o = mode_q;

  // R7
  mode_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && active_o) |=> $stable(mode_q));

endmodule

// File: rtl/u2x_dwell_cnt.sv
`timescale 1ns/1ps
module u2x_dwell_cnt
  import u2x_pkg::*;
#(
  parameter int unsigned SHORT_CYC = 50,
  parameter int unsigned LONG_CYC  = 1600,
  parameter int unsigned CNT_W     = 11
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       active_i,
  input  logic       lfps_s_i,
  input  filt_mode_e mode_i,
  output logic       fire_o
);

  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_CYC - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic [CNT_W-1:0] last;

  assign last   = (mode_i == FILT_LONG) ? LONG_LAST : SHORT_LAST;
  assign fire_o = active_i & ~done_q & (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (!active_i) cnt_q <= '0;
    else if (!done_q) cnt_q <= cnt_q + CNT_W'(1);
  end

  // Re-arm only after LFPS itself drops.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else if (!lfps_s_i) done_q <= 1'b0;
    else if (fire_o) done_q <= 1'b1;
  end

  // R4
  gap_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> (cnt_q == '0));

  // R6
  one_shot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> (done_q || !lfps_s_i));

  // R3
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(LONG_CYC));

endmodule

// File: rtl/u2_exit_qual.sv
`timescale 1ns/1ps
module u2_exit_qual
  import u2x_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 5000,
  parameter int unsigned SHORT_NS      = 248,
  parameter int unsigned LONG_NS       = 8000,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lfps_det_i,
  input  logic in_u2_i,
  input  logic long_filt_i,
  output logic u2_exit_o
);

  localparam int unsigned SHORT_CYC = cycles_for(SHORT_NS, CLK_PERIOD_PS);
  localparam int unsigned LONG_CYC  = cycles_for(LONG_NS, CLK_PERIOD_PS);
  localparam int unsigned MAX_CYC   = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int unsigned CNT_W     = $clog2(MAX_CYC + 1);

  logic       lfps_s;
  logic       active;
  logic       fire;
  filt_mode_e burst_mode;
  logic       exit_q;

  u2x_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (lfps_det_i),
    .q_o    (lfps_s)
  );

  u2x_burst_track i_track (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lfps_s_i (lfps_s),
    .in_u2_i  (in_u2_i),
    .mode_i   (filt_mode_e'(long_filt_i)),
    .active_o (active),
    .mode_o   (burst_mode)
  );

  u2x_dwell_cnt #(
    .SHORT_CYC (SHORT_CYC),
    .LONG_CYC  (MAX_CYC),
    .CNT_W     (CNT_W)
  ) i_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .lfps_s_i (lfps_s),
    .mode_i   (burst_mode),
    .fire_o   (fire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) exit_q <= 1'b0;
    else exit_q <= fire;
  end

  assign u2_exit_o = exit_q;

  // R8
  pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    u2_exit_o |=> !u2_exit_o);

  // R5
  exit_in_u2_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(u2_exit_o) |-> $past(in_u2_i, 2));

  // R2
  exit_needs_lfps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(u2_exit_o) |-> $past(lfps_s, 2));

endmodule

// File: tb/test_u2_exit_qual.sv
`timescale 1ns/1ps
module test_u2_exit_qual;

  localparam int SYNC    = 2;
  localparam int SHORT_T = (248 * 1000 + 5000 - 1) / 5000;
  localparam int LONG_T  = (8000 * 1000 + 5000 - 1) / 5000;

  localparam int VEC_N = 7;
  localparam logic V_MODE [VEC_N] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0};
  localparam int   V_LEN  [VEC_N] = '{SHORT_T, SHORT_T-1, 200, LONG_T, LONG_T-1, 100, 5};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lfps = 1'b0;
  logic in_u2 = 1'b0;
  logic mode = 1'b0;
  logic exit_w;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  u2_exit_qual i_u2_exit_qual (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .lfps_det_i  (lfps),
    .in_u2_i     (in_u2),
    .long_filt_i (mode),
    .u2_exit_o   (exit_w)
  );

  task automatic check_int(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive one burst of len edges; returns pulse count and index of first pulse.
  task automatic burst(input logic m, input int len, input int flip_at,
                       output int n, output int first);
    n = 0; first = 0;
    @(negedge clk); mode = m; lfps = 1'b1;
    for (int i = 1; i <= len + SYNC + 4; i++) begin
      @(posedge clk); @(negedge clk);
      if (exit_w) begin n++; if (first == 0) first = i; end
      if (i == flip_at) mode = ~mode;
      if (i == len) lfps = 1'b0;
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int n, first;
    // R1 reset state
    repeat (3) @(negedge clk);
    check_int("R1 in reset", int'(exit_w), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check_int("R1 after reset", int'(exit_w), 0);
    in_u2 = 1'b1;
    repeat (3) @(negedge clk);

    // Vector table: R2, R3, R4, R6
    for (int v = 0; v < VEC_N; v++) begin
      int thr, exp_n;
      thr = V_MODE[v] ? LONG_T : SHORT_T;
      exp_n = (V_LEN[v] >= thr) ? 1 : 0;
      burst(V_MODE[v], V_LEN[v], 0, n, first);
      check_int(V_MODE[v] ? "R3 pulse count" : "R2 pulse count", n, exp_n);
      if (exp_n == 1)
        check_int(V_MODE[v] ? "R3 pulse cycle" : "R2 pulse cycle", first, SYNC + thr);
      repeat (4) @(negedge clk);
    end

    // R7: mode flipped mid-burst, short start
    burst(1'b0, 120, 10, n, first);
    check_int("R7 short held count", n, 1);
    check_int("R7 short held cycle", first, SYNC + SHORT_T);
    repeat (4) @(negedge clk);
    // R7: long start, flipped to short later
    burst(1'b1, 300, 10, n, first);
    check_int("R7 long held count", n, 0);
    repeat (4) @(negedge clk);

    // R4: two pieces of 40 separated by a one-cycle gap
    n = 0;
    @(negedge clk); mode = 1'b0; lfps = 1'b1;
    for (int i = 1; i <= 81 + SYNC + 4; i++) begin
      @(posedge clk); @(negedge clk);
      if (exit_w) n++;
      if (i == 40) lfps = 1'b0;
      if (i == 41) lfps = 1'b1;
      if (i == 81) lfps = 1'b0;
    end
    check_int("R4 gap clears count", n, 0);
    repeat (4) @(negedge clk);

    // R6: 60 high, 1 low, 60 high gives two pulses
    n = 0; first = 0;
    begin
      int second;
      second = 0;
      @(negedge clk); lfps = 1'b1;
      for (int i = 1; i <= 121 + SYNC + 4; i++) begin
        @(posedge clk); @(negedge clk);
        if (exit_w) begin
          n++;
          if (first == 0) first = i; else second = i;
        end
        if (i == 60) lfps = 1'b0;
        if (i == 61) lfps = 1'b1;
        if (i == 121) lfps = 1'b0;
      end
      check_int("R6 rearm count", n, 2);
      check_int("R6 first cycle", first, SYNC + SHORT_T);
      check_int("R6 second cycle", second, 61 + SYNC + SHORT_T);
    end
    repeat (4) @(negedge clk);

    // R5: gating by in_u2, one-cycle drop restarts
    n = 0; first = 0;
    @(negedge clk); in_u2 = 1'b0; mode = 1'b0; lfps = 1'b1;
    for (int i = 1; i <= 200; i++) begin
      @(posedge clk); @(negedge clk);
      if (exit_w) begin n++; if (first == 0) first = i; end
      if (i == 100) begin
        check_int("R5 no pulse outside U2", n, 0);
        in_u2 = 1'b1;
      end
      if (i == 120) in_u2 = 1'b0;
      if (i == 121) in_u2 = 1'b1;
    end
    lfps = 1'b0;
    check_int("R5 restart count", n, 1);
    check_int("R5 restart cycle", first, 121 + SHORT_T);
    repeat (8) @(negedge clk);
    check_int("R1 idle after all", int'(exit_w), 0);

    finish_run();
  end

endmodule